// File: doc/BRIEF.md
# Triple Interval Timer

A bus-attached peripheral with three independent 16-bit up-counters. Each counter has a power-of-two prescaler in front of it. It can be stopped and resumed, zeroed by a control write, and run in one of two modes. In free-running mode it wraps from 0xFFFF to 0 and flags an overflow. In interval mode it climbs to a programmed limit, flags an interval event and then starts again from zero. Each counter drives its own interrupt line. The line is the OR of its pending event flags, each masked by an enable bit.

Software uses a simple synchronous register bus with separate write and read strobes, an 8-bit byte address and 32-bit data. Read data appears on the cycle after the read strobe. Each kind of register has a base offset, and the copy for timer n sits at that base plus 4·n:

| Register | Timer 0 | Timer 1 | Timer 2 |
|---|---|---|---|
| clock config | 0x00 | 0x04 | 0x08 |
| run control | 0x0C | 0x10 | 0x14 |
| count | 0x18 | 0x1C | 0x20 |
| limit | 0x24 | 0x28 | 0x2C |
| event flags | 0x54 | 0x58 | 0x5C |
| event enable | 0x60 | 0x64 | 0x68 |

Top module: `trio_timer`

## Requirements
- R1: After reset, clock config and run control read 0 and limit reads 0xFFFF. Event flags and event enable read 0, and every irq bit is low. With these values the counters run at one tick per clock.
- R2: Clock config stores bits [5:0] and reads them back: bit 0 enables the prescaler, bits [4:1] hold exponent N, and bit 5 is a stored spare. Run control stores bits 0, 1 and 5. The limit register stores bits [15:0]. Event enable stores bits 0 and 4. All other bits read 0.
- R3: With the prescaler enabled, the counter advances once every 2^(N+1) clocks. With it off, the counter advances every clock.
- R4: Run control bit 0 set to 1 freezes the count. Clearing it resumes counting from the frozen value.
- R5: A write to run control with bit 4 set zeroes the count and the prescaler phase. Bit 4 is never stored and reads back as 0.
- R6: In free-running mode (run control bit 1 = 0), a tick at 0xFFFF wraps the count to 0 and sets event flag bit 4 (overflow).
- R7: In interval mode (run control bit 1 = 1), the tick that brings the count up to the limit sets event flag bit 0 (interval). The next tick returns the count to 0. Counting from a fresh zero, the first event comes after exactly limit ticks, and later events come every limit+1 ticks.
- R8: A read of an event flag register returns bit 0 = interval and bit 4 = overflow, then clears them. An event raised in the same cycle as the read stays pending.
- R9: irq[n] is high exactly while timer n has an event flag whose enable bit is set. A pending flag with its enable bit clear leaves irq[n] low.
- R10: Read data is valid on the cycle after rd_en. Writes to count registers are ignored. Addresses with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| irq | output | 3 | Interrupt line per timer |

## Verification
The hardest situations to reach are the 16-bit wrap and an event landing in the very cycle its flag register is read. Both depend on exact tick timing and cannot be set up directly from the ports. The stimulus first zeroes a counter with the reset bit, which gives a known time origin. It then counts clock edges to the 65536-tick overflow with the prescaler off. For the collision, the limit is set to 1, so an interval event fires on every other tick. A read timed from the zeroing write then lands exactly on an event, and the flag must stay pending.

// File: rtl/trio_timer_pkg.sv
package trio_timer_pkg;

    // Width of the prescaler exponent field
    localparam int unsigned PRE_EXP_W = 4;
    // Address step between copies of the same register kind
    localparam int unsigned REG_STRIDE = 4;

    // Base offsets of each register kind (timer 0)
    localparam logic [7:0] OFS_CLK = 8'h00;
    localparam logic [7:0] OFS_RUN = 8'h0C;
    localparam logic [7:0] OFS_VAL = 8'h18;
    localparam logic [7:0] OFS_LIM = 8'h24;
    localparam logic [7:0] OFS_FLG = 8'h54;
    localparam logic [7:0] OFS_ENA = 8'h60;

    // Clock config, packed so bit order matches the register image [5:0]
    typedef struct packed {
        logic                 spare;
        logic [PRE_EXP_W-1:0] exp_n;
        logic                 pre_en;
    } clk_cfg_t;

    // Run control, stored bits only
    typedef struct packed {
        logic spare;
        logic intv_mode;
        logic halt;
    } run_cfg_t;

    // Event flags or enables
    typedef struct packed {
        logic ovf;
        logic ivl;
    } evt_t;

endpackage

// File: rtl/trio_prescaler.sv
module trio_prescaler
    import trio_timer_pkg::*;
#(
    parameter int unsigned EXP_W = PRE_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] exp_n,
    output logic             tick
);

    localparam int unsigned DIV_W = 2 ** EXP_W;

    typedef struct packed {
        logic [DIV_W-1:0] acc;
    } pre_st_t;

    pre_st_t        st_d, st_q;
    logic [DIV_W:0] span;
    logic [DIV_W-1:0] mask;

    always_comb begin
        st_d = st_q;
        span = (DIV_W + 1)'(1) << (int'(exp_n) + 1);
        mask = DIV_W'(span - 1'b1);
        tick = run && (!pre_en || ((st_q.acc & mask) == mask));
        if (clear) begin
            st_d.acc = '0;
        end else if (run && pre_en) begin
            st_d.acc = st_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/trio_channel.sv
module trio_channel
    import trio_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             intv_mode,
    input  logic             rd_clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output evt_t             flags,
    output evt_t             evt
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        evt_t             flags;
    } ch_st_t;

    ch_st_t           st_d, st_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        evt  = '0;
        nxt  = st_q.count + 1'b1;
        if (clear) begin
            st_d.count = '0;
        end else if (tick) begin
            if (intv_mode && (st_q.count == limit)) begin
                st_d.count = '0;
            end else begin
                st_d.count = nxt;
                evt.ivl    = intv_mode && (nxt == limit);
                evt.ovf    = (st_q.count == '1);
            end
        end
        st_d.flags = evt_t'((rd_clr ? 2'b00 : st_q.flags) | evt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign flags = st_q.flags;

endmodule

// File: rtl/trio_timer.sv
module trio_timer
    import trio_timer_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_TIMERS-1:0] irq
);

    localparam int unsigned CLK_W = $bits(clk_cfg_t);

    typedef struct packed {
        clk_cfg_t [NUM_TIMERS-1:0]            clk_cfg;
        run_cfg_t [NUM_TIMERS-1:0]            run_cfg;
        logic [NUM_TIMERS-1:0][CNT_W-1:0]     limit;
        evt_t [NUM_TIMERS-1:0]                ena;
        logic [DATA_W-1:0]                    rdata;
    } regs_t;

    regs_t                            r_d, r_q;
    logic [DATA_W-1:0]                rd_mux;
    logic [NUM_TIMERS-1:0]            clr_hit;
    logic [NUM_TIMERS-1:0]            flg_rd;
    logic [NUM_TIMERS-1:0]            tick_w;
    logic [NUM_TIMERS-1:0]            halt_w;
    logic [NUM_TIMERS-1:0]            imode_w;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] lim_w;
    evt_t [NUM_TIMERS-1:0]            flg_w;
    evt_t [NUM_TIMERS-1:0]            evt_w;
    logic                             unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    function automatic logic [ADDR_W-1:0] reg_addr(input logic [7:0] base, input int idx);
        return ADDR_W'(int'(base) + REG_STRIDE * idx);
    endfunction

    always_comb begin
        r_d     = r_q;
        rd_mux  = '0;
        clr_hit = '0;
        flg_rd  = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (wr_en) begin
                if (addr == reg_addr(OFS_CLK, i)) begin
                    r_d.clk_cfg[i] = clk_cfg_t'(wdata[CLK_W-1:0]);
                end
                if (addr == reg_addr(OFS_RUN, i)) begin
                    r_d.run_cfg[i] = '{spare: wdata[5], intv_mode: wdata[1], halt: wdata[0]};
                    clr_hit[i]     = wdata[4];
                end
                if (addr == reg_addr(OFS_LIM, i)) begin
                    r_d.limit[i] = wdata[CNT_W-1:0];
                end
                if (addr == reg_addr(OFS_ENA, i)) begin
                    r_d.ena[i] = '{ovf: wdata[4], ivl: wdata[0]};
                end
            end
            if (rd_en) begin
                if (addr == reg_addr(OFS_CLK, i)) begin
                    rd_mux = DATA_W'(r_q.clk_cfg[i]);
                end
                if (addr == reg_addr(OFS_RUN, i)) begin
                    rd_mux = DATA_W'({r_q.run_cfg[i].spare, 3'b000,
                                      r_q.run_cfg[i].intv_mode, r_q.run_cfg[i].halt});
                end
                if (addr == reg_addr(OFS_VAL, i)) begin
                    rd_mux = DATA_W'(cnt_w[i]);
                end
                if (addr == reg_addr(OFS_LIM, i)) begin
                    rd_mux = DATA_W'(r_q.limit[i]);
                end
                if (addr == reg_addr(OFS_FLG, i)) begin
                    rd_mux    = DATA_W'({flg_w[i].ovf, 3'b000, flg_w[i].ivl});
                    flg_rd[i] = 1'b1;
                end
                if (addr == reg_addr(OFS_ENA, i)) begin
                    rd_mux = DATA_W'({r_q.ena[i].ovf, 3'b000, r_q.ena[i].ivl});
                end
            end
        end
        if (rd_en) begin
            r_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.limit <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        assign halt_w[g]  = r_q.run_cfg[g].halt;
        assign imode_w[g] = r_q.run_cfg[g].intv_mode;
        assign lim_w[g]   = r_q.limit[g];

        trio_prescaler #(
            .EXP_W (PRE_EXP_W)
        ) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (!halt_w[g]),
            .clear  (clr_hit[g]),
            .pre_en (r_q.clk_cfg[g].pre_en),
            .exp_n  (r_q.clk_cfg[g].exp_n),
            .tick   (tick_w[g])
        );

        trio_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_w[g]),
            .clear     (clr_hit[g]),
            .intv_mode (imode_w[g]),
            .rd_clr    (flg_rd[g]),
            .limit     (lim_w[g]),
            .count     (cnt_w[g]),
            .flags     (flg_w[g]),
            .evt       (evt_w[g])
        );

        assign irq[g] = (flg_w[g].ivl && r_q.ena[g].ivl) || (flg_w[g].ovf && r_q.ena[g].ovf);
    end

endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk #(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [DATA_W-1:0]           rdata,
    input logic [NUM_TIMERS-1:0]       tick,
    input logic [NUM_TIMERS-1:0]       halt,
    input logic [NUM_TIMERS-1:0]       imode,
    input logic [NUM_TIMERS-1:0]       clr,
    input logic [NUM_TIMERS-1:0]       flg_rd,
    input logic [NUM_TIMERS*CNT_W-1:0] cnt,
    input logic [NUM_TIMERS*CNT_W-1:0] lim,
    input logic [NUM_TIMERS*2-1:0]     flg,
    input logic [NUM_TIMERS*2-1:0]     evt
);

    // R10: addresses above the last register read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr >= ADDR_W'(8'h6C))) |=> (rdata == '0));

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
        // R4: a halted counter keeps its value
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (halt[g] && !clr[g]) |=> $stable(cnt[g*CNT_W +: CNT_W]));

        // R5: zeroing write clears the count
        a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> (cnt[g*CNT_W +: CNT_W] == '0));

        // R6: free-running wrap sets the overflow flag
        a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && !clr[g] && !imode[g] && (cnt[g*CNT_W +: CNT_W] == '1))
            |=> ((cnt[g*CNT_W +: CNT_W] == '0) && flg[2*g+1]));

        // R7: count at the limit restarts from zero
        a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && !clr[g] && imode[g] && (cnt[g*CNT_W +: CNT_W] == lim[g*CNT_W +: CNT_W]))
            |=> (cnt[g*CNT_W +: CNT_W] == '0));

        // R8: a flag read with no new event leaves nothing pending
        a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (flg_rd[g] && (evt[2*g +: 2] == 2'b00)) |=> (flg[2*g +: 2] == 2'b00));
    end

endmodule

bind trio_timer trio_timer_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .tick   (tick_w),
    .halt   (halt_w),
    .imode  (imode_w),
    .clr    (clr_hit),
    .flg_rd (flg_rd),
    .cnt    (cnt_w),
    .lim    (lim_w),
    .flg    (flg_w),
    .evt    (evt_w)
);

// File: tb/trio_timer_tb_top.sv
module trio_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    trio_timer dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue a read and queue the value the requirements predict
    task automatic rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Poll irq bit at negedges; n counts negedges since the last write edge
    task automatic wait_irq(input int bit_i, input int start, output int n);
        n = start;
        while (irq[bit_i] !== 1'b1 && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Monitor: compare read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check_val("R10 unexpected read data", rdata, 32'hDEAD_BEEF);
            end else begin
                check_val(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check_val("R1 irq after reset", 32'(irq), 32'h0);
        rd(8'h00, 32'h0, "R1 clock config t0");
        rd(8'h10, 32'h0, "R1 run control t1");
        rd(8'h24, 32'hFFFF, "R1 limit t0");
        rd(8'h2C, 32'hFFFF, "R1 limit t2");
        rd(8'h5C, 32'h0, "R1 flags t2");
        rd(8'h64, 32'h0, "R1 enable t1");

        // R4 halt and resume, R5 zeroing, R10 count write ignored
        wr(8'h0C, 32'h11);
        rd(8'h18, 32'h0, "R5 count zeroed and halted");
        repeat (6) @(negedge clk);
        rd(8'h18, 32'h0, "R4 halted count holds");
        wr(8'h0C, 32'h00);
        repeat (8) @(negedge clk);
        wr(8'h0C, 32'h01);
        rd(8'h18, 32'd10, "R4 count after run window");
        wr(8'h0C, 32'h00);
        repeat (3) @(negedge clk);
        wr(8'h0C, 32'h01);
        rd(8'h18, 32'd15, "R4 resume continues from frozen value");
        wr(8'h18, 32'h1234);
        rd(8'h18, 32'd15, "R10 count write ignored");
        rd(8'h40, 32'h0, "R10 unmapped address");

        // R6 free-running wrap, R9 masking
        wr(8'h68, 32'h10);
        wr(8'h14, 32'h10);
        wait_irq(2, 1, n);
        check_val("R6 overflow after 65536 ticks", 32'(n), 32'd65537);
        rd(8'h5C, 32'h10, "R6 overflow flag bit 4");
        rd(8'h5C, 32'h0, "R8 flags cleared by read");
        check_val("R9 irq drops after clear", 32'(irq[2]), 32'h0);

        // R9 flag pending but not enabled on timer 1
        check_val("R9 masked flag keeps irq low", 32'(irq[1]), 32'h0);
        rd(8'h58, 32'h10, "R9 masked overflow still pending");

        // R7 interval mode with R3 prescale divide by 4
        wr(8'h24, 32'd5);
        wr(8'h00, 32'h03);
        wr(8'h60, 32'h01);
        wr(8'h0C, 32'h12);
        wait_irq(0, 1, n);
        check_val("R7 R3 first interval event timing", 32'(n), 32'd21);
        rd(8'h18, 32'd5, "R7 count holds limit until next tick");
        rd(8'h54, 32'h01, "R7 interval flag bit 0");
        check_val("R8 irq low after flag read", 32'(irq[0]), 32'h0);
        rd(8'h54, 32'h0, "R8 flags empty");
        wait_irq(0, 27, n);
        check_val("R7 R3 period limit plus one ticks", 32'(n), 32'd45);

        // R7 limit 1 boundary, R8 event coinciding with read
        rd(8'h5C, 32'h0, "R8 timer 2 flags empty");
        wr(8'h68, 32'h01);
        wr(8'h2C, 32'd1);
        wr(8'h14, 32'h12);
        wait_irq(2, 1, n);
        check_val("R7 limit 1 event after one tick", 32'(n), 32'd2);
        rd(8'h5C, 32'h01, "R8 read in event cycle");
        check_val("R8 concurrent event stays pending", 32'(irq[2]), 32'h1);
        wr(8'h14, 32'h01);
        rd(8'h5C, 32'h01, "R8 pending event returned");
        rd(8'h5C, 32'h0, "R8 cleared after halt");

        // R2 and R5 readback of stored bits
        wr(8'h10, 32'h23);
        rd(8'h10, 32'h23, "R2 run control stored bits");
        wr(8'h10, 32'h33);
        rd(8'h10, 32'h23, "R5 zeroing bit self clears");
        rd(8'h1C, 32'h0, "R5 timer 1 count zeroed");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h3F, "R2 clock config bits 5 to 0");
        wr(8'h28, 32'hFFFF_1234);
        rd(8'h28, 32'h1234, "R2 limit 16 bits");
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h64, 32'h11, "R2 enable bits 0 and 4");

        repeat (2) @(negedge clk);
        check_val("R10 all reads answered", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule